// File: doc/BRIEF.md
# Truth-Table Programmable Logic Unit

This block applies any one of the sixteen two-input Boolean functions to every bit pair of two equal-width operands. The function is not named by an opcode; it is supplied directly as a 4-bit truth table. Each result bit comes from its own bit slice, a 4-to-1 multiplexer whose select lines are the two operand bits and whose data inputs are the four truth-table bits. A unit enable gates every slice, so a disabled unit produces all zeros.

Operands, code and enable travel together as one beat on a valid/ready input stream. The result leaves on a valid/ready output stream through a single register stage. A beat is accepted in any cycle where `in_valid` and `in_ready` are both high. `in_ready` is high when the stage is empty or when the held result is being taken in the same cycle. While the output is valid and `out_ready` is low, the held result does not change and no new beat is accepted.

Top module: `tt_logic_unit`

## Requirements
- R1: For every bit position i, result bit i equals code bit k, where k = 2*A[i] + B[i] (A is the upper select line, B the lower one; code bit 0 covers row A=0,B=0 and code bit 3 covers row A=1,B=1).
- R2: Fixed codes produce these functions: 4'b1110 gives OR, 4'b0111 gives NAND, 4'b1000 gives AND, 4'b0110 gives XOR, 4'b0000 gives all zeros and 4'b1111 gives all ones.
- R3: A beat accepted with `in_enable` low yields an all-zero result, whatever the operands and code.
- R4: With A = 8'h1E and B = 8'h98, the OR code yields 8'h9E and the AND code yields 8'h18.
- R5: A beat accepted at a clock edge appears on `out_f` with `out_valid` high immediately after that edge.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_f` stays unchanged on the next edge.
- R7: `in_ready` is high exactly when the output stage is empty or `out_ready` is high; a beat offered while `in_ready` is low is not taken.
- R8: After reset, `out_valid` is low, `out_f` is zero and `in_ready` is high.
- R9: When the held result is taken and no new beat is accepted in the same cycle, `out_valid` falls after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Input beat can be accepted |
| in_a | input | WIDTH | Operand A (upper select) |
| in_b | input | WIDTH | Operand B (lower select) |
| in_code | input | 4 | Truth-table function code |
| in_enable | input | 1 | Unit enable for this beat, 1 = active |
| out_valid | output | 1 | Result held on `out_f` |
| out_ready | input | 1 | Downstream takes the result |
| out_f | output | WIDTH | Bitwise result |

## Verification
The two functions that meet in one cycle are the hand-off of a held result to downstream and the acceptance of a fresh beat into the same register. The bench provokes this by stalling the output with a beat already held while a second beat waits, then raising `out_ready` so both happen at the same edge; it judges that the second result replaces the first with no gap and no loss. The function itself is swept over every code, both enable values and all operand row combinations, with expected values formed as a sum of minterms in the bench.

// File: rtl/tt_logic_pkg.sv
package tt_logic_pkg;
  localparam int CODE_W = 4;
  typedef logic [CODE_W-1:0] tt_code_t;

  localparam tt_code_t TT_ZERO = 4'b0000;
  localparam tt_code_t TT_AND  = 4'b1000;
  localparam tt_code_t TT_XOR  = 4'b0110;
  localparam tt_code_t TT_OR   = 4'b1110;
  localparam tt_code_t TT_NAND = 4'b0111;
  localparam tt_code_t TT_ONE  = 4'b1111;
endpackage

// File: rtl/tt_bit_slice.sv
module tt_bit_slice
  import tt_logic_pkg::*;
(
  input  logic     a_bit,
  input  logic     b_bit,
  input  tt_code_t code,
  input  logic     enable,
  output logic     f_bit
);
  logic [1:0] sel;
  logic       picked;

  assign sel = {a_bit, b_bit};

  always_comb begin
    unique case (sel)
      2'd0: picked = code[0];
      2'd1: picked = code[1];
      2'd2: picked = code[2];
      default: picked = code[3];
    endcase
  end

  assign f_bit = enable & picked;
endmodule

// File: rtl/tt_slice_array.sv
module tt_slice_array
  import tt_logic_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  tt_code_t         code,
  input  logic             enable,
  output logic [WIDTH-1:0] f
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    tt_bit_slice u_slice (
      .a_bit  (a[i]),
      .b_bit  (b[i]),
      .code   (code),
      .enable (enable),
      .f_bit  (f[i])
    );
  end
endmodule

// File: rtl/tt_stream_stage.sv
module tt_stream_stage #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_valid,
  output logic             up_ready,
  input  logic [WIDTH-1:0] up_data,
  output logic             dn_valid,
  input  logic             dn_ready,
  output logic [WIDTH-1:0] dn_data
);
  logic take;

  assign up_ready = !dn_valid || dn_ready;
  assign take     = up_valid && up_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
      dn_data  <= '0;
    end else if (take) begin
      dn_valid <= 1'b1;
      dn_data  <= up_data;
    end else if (dn_ready) begin
      dn_valid <= 1'b0;
    end
  end

  // R6: a stalled result is held
  a_r6_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_ready |=> dn_valid && $stable(dn_data));

  // R5: an accepted beat is presented next cycle
  a_r5_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid && up_ready |=> dn_valid);

  // R9: consumed with nothing new means empty
  a_r9_drain: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && dn_ready && !up_valid |=> !dn_valid);
endmodule

// File: rtl/tt_logic_unit.sv
module tt_logic_unit
  import tt_logic_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  input  logic [3:0]       in_code,
  input  logic             in_enable,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_f
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  logic [WIDTH-1:0] comb_f;

  tt_slice_array #(.WIDTH(WIDTH)) u_array (
    .a      (in_a),
    .b      (in_b),
    .code   (tt_code_t'(in_code)),
    .enable (in_enable),
    .f      (comb_f)
  );

  tt_stream_stage #(.WIDTH(WIDTH)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (comb_f),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (out_f)
  );

  // R3: disabled beat yields zero
  a_r3_disabled_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_enable |=> out_f == '0);

  // R2: constant-one code fills the word
  a_r2_const_one: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_enable && in_code == TT_ONE |=> out_f == ALL_ONES);

  // R2: constant-zero code clears the word
  a_r2_const_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_code == TT_ZERO |=> out_f == '0);

  // R1: operands equal to each other with XOR code give zero
  a_r1_xor_self: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_code == TT_XOR && in_a == in_b |=> out_f == '0);
endmodule

// File: tb/tt_logic_unit_tb.sv
module tt_logic_unit_tb;
  localparam int W = 8;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG_CYCLES = 150000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_a = '0;
  logic [W-1:0] in_b = '0;
  logic [3:0]   in_code = '0;
  logic         in_enable = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [W-1:0] out_f;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tt_logic_unit #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_code(in_code), .in_enable(in_enable),
    .out_valid(out_valid), .out_ready(out_ready), .out_f(out_f)
  );

  function automatic logic [W-1:0] model(logic [W-1:0] a, logic [W-1:0] b,
                                         logic [3:0] c, logic en);
    logic [W-1:0] r;
    r = ((~a & ~b) & {W{c[0]}}) | ((~a & b) & {W{c[1]}}) |
        ((a & ~b) & {W{c[2]}})  | ((a & b) & {W{c[3]}});
    return en ? r : '0;
  endfunction

  task automatic check(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one beat with downstream ready, check it one edge later
  task automatic beat(logic [W-1:0] a, logic [W-1:0] b, logic [3:0] c, logic en, string req);
    logic [W-1:0] exp;
    exp = model(a, b, c, en);
    @(negedge clk);
    in_valid = 1'b1; in_a = a; in_b = b; in_code = c; in_enable = en; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, "R5", W'(out_valid), W'(1));
    check(out_f == exp, req, out_f, exp);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG_CYCLES && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG_CYCLES);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: reset state
    check(out_valid == 1'b0, "R8", W'(out_valid), W'(0));
    check(out_f == '0, "R8", out_f, '0);
    check(in_ready == 1'b1, "R8", W'(in_ready), W'(1));

    // R4: worked example
    beat(8'h1E, 8'h98, 4'b1110, 1'b1, "R4");
    check(out_f == 8'h9E, "R4", out_f, 8'h9E);
    beat(8'h1E, 8'h98, 4'b1000, 1'b1, "R4");
    check(out_f == 8'h18, "R4", out_f, 8'h18);

    // R2: named codes against operator results
    beat(8'hCA, 8'h5C, 4'b1110, 1'b1, "R2");
    check(out_f == (8'hCA | 8'h5C), "R2", out_f, 8'hCA | 8'h5C);
    beat(8'hCA, 8'h5C, 4'b0111, 1'b1, "R2");
    check(out_f == ~(8'hCA & 8'h5C), "R2", out_f, ~(8'hCA & 8'h5C));
    beat(8'hCA, 8'h5C, 4'b1000, 1'b1, "R2");
    check(out_f == (8'hCA & 8'h5C), "R2", out_f, 8'hCA & 8'h5C);
    beat(8'hCA, 8'h5C, 4'b0110, 1'b1, "R2");
    check(out_f == (8'hCA ^ 8'h5C), "R2", out_f, 8'hCA ^ 8'h5C);
    beat(8'hCA, 8'h5C, 4'b0000, 1'b1, "R2");
    check(out_f == 8'h00, "R2", out_f, 8'h00);
    beat(8'hCA, 8'h5C, 4'b1111, 1'b1, "R2");
    check(out_f == 8'hFF, "R2", out_f, 8'hFF);

    // R1 / R3: sweep all codes, both enables, all nibble pairs
    for (int en = 0; en < 2; en++)
      for (int c = 0; c < 16; c++)
        for (int a = 0; a < 16; a++)
          for (int b = 0; b < 16; b++)
            beat({a[3:0], ~a[3:0]}, {b[3:0], b[3:0] ^ 4'h5}, c[3:0], en[0],
                 en == 0 ? "R3" : "R1");

    // R6 / R7: stall, then hand-off and accept in the same edge
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_a = 8'hF0; in_b = 8'h3C; in_code = 4'b0110; in_enable = 1'b1;
    @(negedge clk);
    held = out_f;
    check(out_f == 8'hCC, "R5", out_f, 8'hCC);
    check(in_ready == 1'b0, "R7", W'(in_ready), W'(0));
    in_a = 8'h0F; in_b = 8'hFF; in_code = 4'b1000;
    repeat (3) begin
      @(negedge clk);
      check(out_valid == 1'b1, "R6", W'(out_valid), W'(1));
      check(out_f == held, "R6", out_f, held);
      check(in_ready == 1'b0, "R7", W'(in_ready), W'(0));
    end
    out_ready = 1'b1;
    #1;
    check(in_ready == 1'b1, "R7", W'(in_ready), W'(1));
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, "R7", W'(out_valid), W'(1));
    check(out_f == 8'h0F, "R7", out_f, 8'h0F);
    @(negedge clk);
    // R9: drained
    check(out_valid == 1'b0, "R9", W'(out_valid), W'(0));
    check(in_ready == 1'b1, "R9", W'(in_ready), W'(1));

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule